// File: doc/BRIEF.md
# Repeat-or-Hold Flag Machine

This block watches two single-bit inputs and raises one registered flag. The flag goes high when input `a_in` has shown the same value on two clock edges in a row. Once high, it stays high for as long as input `b_in` is 1 on every later edge, even if `a_in` stops repeating. When both conditions fail on an edge, the flag falls.

The machine holds three independent state bits:
- a "sampled" bit, set once the first post-reset sample of `a_in` has been taken;
- a "hold" bit, which drives the output;
- a copy of the most recent `a_in` sample.

Together these bits cover five reachable logical states. The output comes straight from the hold bit, so it only moves at a clock edge.

Top module: `repeat_hold_flag`

## Requirements
- R1: While `rst` is 1 at an edge, `z_out` is 0 after that edge. On the first edge after reset is released, `z_out` stays 0 whatever the values of `a_in` and `b_in`, because no earlier sample exists to compare against.
- R2: If `a_in` is 0 at an edge and was also 0 at the previous post-reset edge, `z_out` is 1 after that edge.
- R3: If `a_in` is 1 at an edge and was also 1 at the previous post-reset edge, `z_out` is 1 after that edge.
- R4: If `z_out` is 1 and `b_in` is 1 at an edge, `z_out` stays 1 after that edge, even when `a_in` differs from its previous sample.
- R5: If `z_out` is 1, `b_in` is 0, and `a_in` differs from its previous sample at an edge, `z_out` becomes 0.
- R6: If `z_out` is 0 and `a_in` differs from its previous sample, `z_out` stays 0. The value of `b_in` has no effect in this case.
- R7: `z_out` changes only at a rising clock edge. A change of `a_in` or `b_in` between edges does not reach it.
- R8: Reset is synchronous and takes effect mid-operation. An edge with `rst` at 1 clears `z_out` and discards the stored sample of `a_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 1 | Input whose repetition across two edges sets the flag |
| b_in | input | 1 | Input that keeps the flag high while it stays 1 |
| z_out | output | 1 | Registered flag |

## Verification
The assertions assume three things about the inputs:
- `rst` is held high from time zero through at least one edge;
- `a_in` and `b_in` are settled before each rising edge;
- no input is X or Z.

The checker keeps its own copy of the previous `a_in` sample and a flag marking the first post-reset edge.

The stimulus meets these assumptions:
- inputs are applied only at falling edges;
- reset is asserted before the first rising edge;
- one mid-cycle input change is made purely to show that `z_out` does not follow it.

// File: rtl/rhf_pkg.sv
package rhf_pkg;

   // Decomposed state: each field carries one meaning.
   typedef struct packed {
      logic sampled;   // at least one a sample since reset
      logic hold;      // drives the output flag
      logic last_a;    // previous a sample
   } rhf_state_t;

   localparam int unsigned RHF_STATE_BITS = $bits(rhf_state_t);
   localparam int unsigned RHF_LOGICAL_STATES = 5;

endpackage

// File: rtl/rhf_sample_hist.sv
module rhf_sample_hist #(
   parameter int unsigned DATA_W = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] a_in,
   output logic              sampled_q,
   output logic [DATA_W-1:0] last_a_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         sampled_q <= 1'b0;
         last_a_q  <= '0;
      end else begin
         sampled_q <= 1'b1;
         last_a_q  <= a_in;
      end
   end

endmodule

// File: rtl/rhf_repeat_detect.sv
module rhf_repeat_detect #(
   parameter int unsigned DATA_W = 1
) (
   input  logic              sampled,
   input  logic [DATA_W-1:0] last_a,
   input  logic [DATA_W-1:0] a_in,
   output logic              repeat_hit
);

   localparam logic [DATA_W-1:0] ALL_ZERO = '0;

   logic zero_pair;
   logic nonzero_pair;

   // A zero pair needs the sampled bit, since the cleared history also reads zero.
   // A nonzero stored sample can only exist after a real sample was taken.
   always_comb begin
      zero_pair    = sampled && (last_a == ALL_ZERO) && (a_in == ALL_ZERO);
      nonzero_pair = (last_a != ALL_ZERO) && (a_in == last_a);
      repeat_hit   = zero_pair || nonzero_pair;
   end

endmodule

// File: rtl/rhf_hold_reg.sv
module rhf_hold_reg (
   input  logic clk,
   input  logic rst,
   input  logic repeat_hit,
   input  logic keep,
   output logic hold_q
);

   logic hold_d;

   always_comb begin
      hold_d = repeat_hit || (hold_q && keep);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         hold_q <= 1'b0;
      end else begin
         hold_q <= hold_d;
      end
   end

endmodule

// File: rtl/repeat_hold_flag.sv
module repeat_hold_flag #(
   parameter int unsigned A_WIDTH = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic a_in,
   input  logic b_in,
   output logic z_out
);

   import rhf_pkg::*;

   localparam int unsigned HIST_W = A_WIDTH;

   if (RHF_STATE_BITS != 3) begin : g_bad_state
      $error("repeat_hold_flag: state must be three bits");
   end
   if (A_WIDTH != 1) begin : g_bad_width
      $error("repeat_hold_flag: A_WIDTH must be 1");
   end

   logic              sampled_q;
   logic [HIST_W-1:0] last_a_q;
   logic              repeat_hit;
   logic              hold_q;
   rhf_state_t        state;

   rhf_sample_hist #(.DATA_W(HIST_W)) u_hist (
      .clk       (clk),
      .rst       (rst),
      .a_in      (a_in),
      .sampled_q (sampled_q),
      .last_a_q  (last_a_q)
   );

   rhf_repeat_detect #(.DATA_W(HIST_W)) u_detect (
      .sampled    (sampled_q),
      .last_a     (last_a_q),
      .a_in       (a_in),
      .repeat_hit (repeat_hit)
   );

   rhf_hold_reg u_hold (
      .clk        (clk),
      .rst        (rst),
      .repeat_hit (repeat_hit),
      .keep       (b_in),
      .hold_q     (hold_q)
   );

   always_comb begin
      state.sampled = sampled_q;
      state.hold    = hold_q;
      state.last_a  = last_a_q[0];
   end

   // Moore output: taken directly from the hold flop.
   assign z_out = state.hold;

endmodule

// File: rtl/rhf_checker.sv
module rhf_checker (
   input logic clk,
   input logic rst,
   input logic a_in,
   input logic b_in,
   input logic z_out
);

   logic seen;
   logic prev_a;
   logic match;

   always_ff @(posedge clk) begin
      if (rst) begin
         seen <= 1'b0;
      end else begin
         seen <= 1'b1;
      end
      prev_a <= a_in;
   end

   always_comb begin
      match = seen && (a_in == prev_a);
   end

   assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !z_out);

   assert_repeat_zero_R2: assert property (@(posedge clk) disable iff (rst)
      (match && !a_in) |=> z_out);

   assert_repeat_one_R3: assert property (@(posedge clk) disable iff (rst)
      (match && a_in) |=> z_out);

   assert_hold_on_b_R4: assert property (@(posedge clk) disable iff (rst)
      (z_out && b_in) |=> z_out);

   assert_drop_R5: assert property (@(posedge clk) disable iff (rst)
      (z_out && !b_in && !match) |=> !z_out);

   assert_no_set_R6: assert property (@(posedge clk) disable iff (rst)
      (!z_out && !match) |=> !z_out);

endmodule

bind repeat_hold_flag rhf_checker u_chk (
   .clk   (clk),
   .rst   (rst),
   .a_in  (a_in),
   .b_in  (b_in),
   .z_out (z_out)
);

// File: tb/sim_repeat_hold_flag.sv
`timescale 1ns/1ps
module sim_repeat_hold_flag;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic a_in = 1'b0;
   logic b_in = 1'b0;
   logic z_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   bit    exp_q[$];
   string tag_q[$];

   // reference state
   bit m_seen = 1'b0;
   bit m_prev = 1'b0;
   bit m_ok   = 1'b0;

   always #10 clk = ~clk;

   repeat_hold_flag u0 (
      .clk   (clk),
      .rst   (rst),
      .a_in  (a_in),
      .b_in  (b_in),
      .z_out (z_out)
   );

   task automatic drive(input bit r, input bit a, input bit b, input string tag);
      bit    match;
      bit    nok;
      string t;
      @(negedge clk);
      rst  = r;
      a_in = a;
      b_in = b;
      match = m_seen && (a == m_prev);
      if (r) begin
         t = (tag == "") ? "R8" : tag;
         m_seen = 1'b0;
         m_prev = 1'b0;
         m_ok   = 1'b0;
      end else begin
         if (tag != "")        t = tag;
         else if (!m_seen)     t = "R1";
         else if (match && a)  t = "R3";
         else if (match)       t = "R2";
         else if (m_ok && b)   t = "R4";
         else if (m_ok)        t = "R5";
         else                  t = "R6";
         nok    = match || (m_ok && b);
         m_seen = 1'b1;
         m_prev = a;
         m_ok   = nok;
      end
      exp_q.push_back(m_ok);
      tag_q.push_back(t);
   endtask

   // monitor: compares after each edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) begin
            bit    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (z_out !== e) begin
               errors++;
               $display("FAIL %s: z_out actual %b expected %b at %0t", t, z_out, e, $time);
            end
         end
      end
   end

   // watchdog
   initial begin
      for (int cyc = 0; cyc < 5000; cyc++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      drive(1'b1, 1'b0, 1'b0, "R1");
      drive(1'b1, 1'b1, 1'b1, "R1");
      drive(1'b0, 1'b1, 1'b1, "R1");   // first sample, no compare possible
      drive(1'b0, 1'b1, 1'b0, "R3");   // 1,1 repeat
      drive(1'b0, 1'b0, 1'b1, "R4");   // held by b
      drive(1'b0, 1'b1, 1'b1, "R4");
      drive(1'b0, 1'b0, 1'b0, "R5");   // drop
      drive(1'b0, 1'b1, 1'b1, "R6");   // b ignored while low
      drive(1'b0, 1'b0, 1'b1, "R6");
      drive(1'b0, 1'b0, 1'b0, "R2");   // 0,0 repeat
      drive(1'b0, 1'b0, 1'b0, "R2");

      // R7: mid-cycle input change does not reach the output
      @(posedge clk);
      #4;
      a_in = 1'b1;
      b_in = 1'b0;
      #3;
      checks++;
      if (z_out !== m_ok) begin
         errors++;
         $display("FAIL R7: z_out actual %b expected %b", z_out, m_ok);
      end

      // R8: reset in the middle of a held run
      drive(1'b1, 1'b0, 1'b1, "R8");
      drive(1'b0, 1'b0, 1'b1, "R1");   // stored 0 discarded by reset
      drive(1'b0, 1'b0, 1'b0, "R2");

      // random streams
      for (int i = 0; i < 600; i++) begin
         bit r;
         r = ($urandom_range(0, 49) == 0);
         drive(r, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0), "");
      end

      @(negedge clk);
      rst = 1'b0;
      repeat (3) @(posedge clk);
      #5;
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule